// File: doc/BRIEF.md
# Subroutine Return Stack with Shadow Register Restore

This block is the call/return stack of a small 8-bit controller core. Pushes store a return address in a last-in first-out array. Each push also takes a snapshot of the live working register, status register and bank-select register into a single-level shadow set. When the core fetches the 16-bit return opcode, the block pops the newest address and presents it as the next program counter. If the opcode's low bit is set, it also drives the shadow snapshot back onto the three registers with write strobes. If the low bit is clear, the three registers keep their values.

The core runs a four-phase instruction cycle. A `phase` input counts 0, 1, 2, 3 on consecutive clocks. The block decodes the instruction word in phase 0. The pop takes effect on the clock edge that ends phase 3 of that instruction cycle. The results appear as one-clock strobes during phase 0 of the second instruction cycle. A flush pulse is raised at the same time so the core can discard the word it has already fetched. The whole second cycle is a no-operation, and the block ignores any return word presented during it.

Reading an empty stack returns address zero and sets a sticky underflow flag. A push to a full stack is dropped.

Top module: `rs_return_unit`

## Requirements
- R1: The words 0x0012 and 0x0013 are return instructions when `instr_valid` is high in phase 0. The opcode is `instr[15:1]` = 15'h0009 and the restore flag is `instr[0]`. Any other word, a return word with `instr_valid` low, or a return word in phases 1 to 3 causes no pop and no strobe.
- R2: A return presents the most recently pushed, not yet popped address on `pc_next`, with `pc_load` high for exactly one clock, and lowers `stk_level` by one.
- R3: With restore flag 1, `w_restore`, `status_restore` and `bsr_restore` carry the values snapshotted by the latest push. `w_we`, `status_we` and `bsr_we` pulse together for the same clock as `pc_load`.
- R4: With restore flag 0, no register write strobe rises, and `w_restore`, `status_restore` and `bsr_restore` keep their previous values.
- R5: The pop occurs on the clock edge sampled with phase 3 of the instruction cycle whose phase 0 carried the return. Before that edge `pc_load` stays low and `stk_level` is unchanged. Phase encoding: 0, 1, 2, 3 for the four phases.
- R6: `flush` is high for exactly the one clock in which `pc_load` is high.
- R7: A return word presented in phase 0 of the instruction cycle following a pop is ignored. It causes no pop, no strobe, and no change of `stk_level`.
- R8: Each `push_req` clock stores `push_addr` and raises `stk_level` by one, up to 31 entries. A push with 31 entries stored is dropped, and the level stays at 31. Pops return addresses in reverse push order. Every push overwrites the shadow snapshot of `w_live`, `status_live` and `bsr_live`.
- R9: A return with `stk_level` 0 gives `pc_next` = 0 and sets `stk_underflow`. The flag stays set until reset.
- R10: While reset is asserted, `stk_level`, `stk_underflow`, `pc_next`, the restore values and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase | input | 2 | Instruction-cycle phase, 0 to 3 |
| instr | input | 16 | Fetched instruction word |
| instr_valid | input | 1 | `instr` holds a word to execute |
| push_req | input | 1 | Push a return address and snapshot registers |
| push_addr | input | AW (21) | Return address to push |
| w_live | input | DW (8) | Current working register |
| status_live | input | DW (8) | Current status register |
| bsr_live | input | BW (4) | Current bank-select register |
| pc_next | output | AW (21) | Address popped by the last return |
| pc_load | output | 1 | One-clock strobe: load `pc_next` into the program counter |
| w_restore | output | DW (8) | Shadow working-register value |
| w_we | output | 1 | Working-register write strobe |
| status_restore | output | DW (8) | Shadow status value |
| status_we | output | 1 | Status write strobe |
| bsr_restore | output | BW (4) | Shadow bank-select value |
| bsr_we | output | 1 | Bank-select write strobe |
| flush | output | 1 | Discard the already fetched instruction |
| stk_level | output | 5 | Number of stored entries |
| stk_underflow | output | 1 | Sticky: a return found the stack empty |

## Verification
The assertions assume that `phase` counts 0, 1, 2, 3 on consecutive clocks. They also assume that `push_req` never coincides with the phase-3 edge of a return cycle, because the priority between the two only matters outside that case. The stimulus drives every input from one task that steps through all four phases of an instruction cycle. That task raises `push_req` only in phase 1 and presents instructions only in phase 0, so both assumptions hold throughout.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;

  // Upper fifteen bits of the return opcode; bit 0 is the restore flag.
  localparam logic [14:0] RET_OPC_HI = 15'h0009;

  function automatic logic is_return(input logic [15:0] word);
    return word[15:1] == RET_OPC_HI;
  endfunction

endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rs_seq.sv
module rs_seq
  import rs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  phase,
  input  logic [15:0] instr,
  input  logic        instr_valid,
  output logic        pop_go,
  output logic        pop_s
);

  logic pend_q, pend_d;
  logic flag_q, flag_d;
  logic tail_q, tail_d;
  logic take;

  // Next-state logic: capture in Q1, fire in Q4, then spend one cycle idle.
  always_comb begin
    take   = instr_valid && (phase == PH_Q1) && !tail_q && !pend_q
             && is_return(instr);
    pop_go = pend_q && (phase == PH_Q4);
    pend_d = pend_q;
    flag_d = flag_q;
    tail_d = tail_q;
    if (take) begin
      pend_d = 1'b1;
      flag_d = instr[0];
    end
    if (pop_go) begin
      pend_d = 1'b0;
      tail_d = 1'b1;
    end else if (tail_q && (phase == PH_Q4)) begin
      tail_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
      tail_q <= tail_d;
    end
  end

  assign pop_s = flag_q;

endmodule

// File: rtl/rs_stack.sv
module rs_stack #(
  parameter  int AW    = 21,
  parameter  int DEPTH = 31,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] top,
  output logic [LW-1:0] level,
  output logic          underflow
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [LW-1:0] level_q, level_d;
  logic          uf_q, uf_d;
  logic          push_ok, pop_ok, is_empty;

  always_comb begin
    is_empty = (level_q == '0);
    push_ok  = push && !pop && (level_q != FULL_LVL);
    pop_ok   = pop && !is_empty;
    level_d  = level_q;
    if (push_ok)     level_d = level_q + 1'b1;
    else if (pop_ok) level_d = level_q - 1'b1;
    uf_d = uf_q | (pop && is_empty);
    top  = is_empty ? '0 : mem[level_q - 1'b1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      uf_q    <= 1'b0;
    end else begin
      level_q <= level_d;
      uf_q    <= uf_d;
    end
  end

  // Storage: enable-only flops, read guarded by the level.
  always_ff @(posedge clk) begin
    if (push_ok) mem[level_q] <= push_data;
  end

  assign level     = level_q;
  assign underflow = uf_q;

endmodule

// File: rtl/rs_shadow.sv
module rs_shadow #(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] st_in,
  input  logic [BW-1:0] bsr_in,
  output logic [DW-1:0] w_sh,
  output logic [DW-1:0] st_sh,
  output logic [BW-1:0] bsr_sh
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_sh   <= '0;
      st_sh  <= '0;
      bsr_sh <= '0;
    end else if (snap) begin
      w_sh   <= w_in;
      st_sh  <= st_in;
      bsr_sh <= bsr_in;
    end
  end

endmodule

// File: rtl/rs_return_unit.sv
module rs_return_unit
  import rs_pkg::*;
#(
  parameter  int AW    = 21,
  parameter  int DEPTH = 31,
  parameter  int DW    = 8,
  parameter  int BW    = 4,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [1:0]    phase,
  input  logic [15:0]   instr,
  input  logic          instr_valid,
  input  logic          push_req,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] w_live,
  input  logic [DW-1:0] status_live,
  input  logic [BW-1:0] bsr_live,
  output logic [AW-1:0] pc_next,
  output logic          pc_load,
  output logic [DW-1:0] w_restore,
  output logic          w_we,
  output logic [DW-1:0] status_restore,
  output logic          status_we,
  output logic [BW-1:0] bsr_restore,
  output logic          bsr_we,
  output logic          flush,
  output logic [LW-1:0] stk_level,
  output logic          stk_underflow
);

  logic          rst_n_s;
  logic          pop_go, pop_s, snap;
  logic [AW-1:0] top;
  logic [DW-1:0] w_sh, st_sh;
  logic [BW-1:0] bsr_sh;

  logic [AW-1:0] pc_q, pc_d;
  logic          load_q, load_d;
  logic [DW-1:0] w_q, w_d, st_q, st_d;
  logic [BW-1:0] b_q, b_d;
  logic          we_q, we_d;

  rs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_s)
  );

  rs_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .phase       (phase),
    .instr       (instr),
    .instr_valid (instr_valid),
    .pop_go      (pop_go),
    .pop_s       (pop_s)
  );

  rs_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (push_req),
    .push_data (push_addr),
    .pop       (pop_go),
    .top       (top),
    .level     (stk_level),
    .underflow (stk_underflow)
  );

  assign snap = push_req && !pop_go;

  rs_shadow #(.DW(DW), .BW(BW)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .snap   (snap),
    .w_in   (w_live),
    .st_in  (status_live),
    .bsr_in (bsr_live),
    .w_sh   (w_sh),
    .st_sh  (st_sh),
    .bsr_sh (bsr_sh)
  );

  // Output next-state: values hold, strobes default low.
  always_comb begin
    pc_d   = pc_q;
    load_d = 1'b0;
    w_d    = w_q;
    st_d   = st_q;
    b_d    = b_q;
    we_d   = 1'b0;
    if (pop_go) begin
      pc_d   = top;
      load_d = 1'b1;
      if (pop_s) begin
        w_d  = w_sh;
        st_d = st_sh;
        b_d  = bsr_sh;
        we_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q   <= '0;
      load_q <= 1'b0;
      w_q    <= '0;
      st_q   <= '0;
      b_q    <= '0;
      we_q   <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      load_q <= load_d;
      w_q    <= w_d;
      st_q   <= st_d;
      b_q    <= b_d;
      we_q   <= we_d;
    end
  end

  assign pc_next        = pc_q;
  assign pc_load        = load_q;
  assign flush          = load_q;
  assign w_restore      = w_q;
  assign status_restore = st_q;
  assign bsr_restore    = b_q;
  assign w_we           = we_q;
  assign status_we      = we_q;
  assign bsr_we         = we_q;

endmodule

// File: rtl/rs_return_unit_chk.sv
module rs_return_unit_chk #(
  parameter int DEPTH = 31,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic          pc_load,
  input logic          flush,
  input logic          w_we,
  input logic          status_we,
  input logic          bsr_we,
  input logic [LW-1:0] stk_level,
  input logic          stk_underflow
);

  a_r6_flush_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    flush == pc_load);

  a_r3_restore_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
    w_we |-> pc_load);

  a_r3_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (w_we == status_we) && (w_we == bsr_we));

  a_r5_pop_after_q4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_load) |-> $past(phase) == 2'd3);

  a_r2_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && $past(stk_level) != '0) |-> stk_level == LW'($past(stk_level) - 1'b1));

  a_r7_one_pop_per_return: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stk_level <= LW'(DEPTH));

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_underflow |=> stk_underflow);

endmodule

bind rs_return_unit rs_return_unit_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .phase         (phase),
  .pc_load       (pc_load),
  .flush         (flush),
  .w_we          (w_we),
  .status_we     (status_we),
  .bsr_we        (bsr_we),
  .stk_level     (stk_level),
  .stk_underflow (stk_underflow)
);

// File: tb/rs_return_unit_test.sv
module rs_return_unit_test;

  logic        clk;
  logic        arst_n;
  logic [1:0]  phase;
  logic [15:0] instr;
  logic        instr_valid;
  logic        push_req;
  logic [20:0] push_addr;
  logic [7:0]  w_live, status_live;
  logic [3:0]  bsr_live;
  logic [20:0] pc_next;
  logic        pc_load, w_we, status_we, bsr_we, flush, stk_underflow;
  logic [7:0]  w_restore, status_restore;
  logic [3:0]  bsr_restore;
  logic [4:0]  stk_level;

  rs_return_unit uut (
    .clk(clk), .arst_n(arst_n), .phase(phase), .instr(instr),
    .instr_valid(instr_valid), .push_req(push_req), .push_addr(push_addr),
    .w_live(w_live), .status_live(status_live), .bsr_live(bsr_live),
    .pc_next(pc_next), .pc_load(pc_load), .w_restore(w_restore), .w_we(w_we),
    .status_restore(status_restore), .status_we(status_we),
    .bsr_restore(bsr_restore), .bsr_we(bsr_we), .flush(flush),
    .stk_level(stk_level), .stk_underflow(stk_underflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  logic [20:0] m_stk [32];
  int          m_lvl;
  logic        m_uf;
  logic [7:0]  m_w, m_st, e_w, e_st;
  logic [3:0]  m_b, e_b;
  logic [20:0] e_pc;

  // Stimulus table: {kind(2): 0 push / 1 return s=0 / 2 return s=1, addr, w, status, bsr}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 21'h01234, 8'h11, 8'h22, 4'h1},
    {2'd0, 21'h0ABCD, 8'h33, 8'h44, 4'h2},
    {2'd2, 21'h0,     8'h0,  8'h0,  4'h0},
    {2'd0, 21'h1FFFF, 8'h55, 8'h66, 4'h3},
    {2'd0, 21'h00100, 8'h77, 8'h88, 4'h4},
    {2'd1, 21'h0,     8'h0,  8'h0,  4'h0},
    {2'd2, 21'h0,     8'h0,  8'h0,  4'h0},
    {2'd1, 21'h0,     8'h0,  8'h0,  4'h0},
    {2'd0, 21'h10000, 8'hAA, 8'hBB, 4'h5},
    {2'd2, 21'h0,     8'h0,  8'h0,  4'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic icycle(input logic [15:0] ins, input logic v, input logic pu,
                        input logic [20:0] a, input logic [7:0] w,
                        input logic [7:0] st, input logic [3:0] b);
    for (int p = 0; p < 4; p++) begin
      phase       = 2'(p);
      instr       = (p == 0) ? ins : 16'h0000;
      instr_valid = (p == 0) && v;
      push_req    = pu && (p == 1);
      push_addr   = a;
      w_live      = w;
      status_live = st;
      bsr_live    = b;
      @(negedge clk);
    end
    instr_valid = 1'b0;
    push_req    = 1'b0;
  endtask

  task automatic idle();
    icycle(16'h0000, 1'b0, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
  endtask

  task automatic do_push(input logic [20:0] a, input logic [7:0] w,
                         input logic [7:0] st, input logic [3:0] b);
    icycle(16'h0000, 1'b0, 1'b1, a, w, st, b);
    if (m_lvl < 31) begin
      m_stk[m_lvl] = a;
      m_lvl++;
    end
    m_w = w; m_st = st; m_b = b;
    chk("R8", "level after push", 32'(stk_level), 32'(m_lvl));
  endtask

  task automatic model_pop(input logic s);
    if (m_lvl == 0) begin
      e_pc = '0;
      m_uf = 1'b1;
    end else begin
      m_lvl--;
      e_pc = m_stk[m_lvl];
    end
    if (s) begin
      e_w = m_w; e_st = m_st; e_b = m_b;
    end
  endtask

  task automatic do_ret(input logic s);
    icycle({15'h0009, s}, 1'b1, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    model_pop(s);
    chk("R2", "pc_load", 32'(pc_load), 32'd1);
    chk("R2", "pc_next", 32'(pc_next), 32'(e_pc));
    chk("R2", "level after pop", 32'(stk_level), 32'(m_lvl));
    chk("R6", "flush", 32'(flush), 32'd1);
    if (s) begin
      chk("R3", "w_we", 32'(w_we), 32'd1);
      chk("R3", "status_we", 32'(status_we), 32'd1);
      chk("R3", "bsr_we", 32'(bsr_we), 32'd1);
    end else begin
      chk("R4", "w_we", 32'(w_we), 32'd0);
      chk("R4", "status_we", 32'(status_we), 32'd0);
      chk("R4", "bsr_we", 32'(bsr_we), 32'd0);
    end
    chk(s ? "R3" : "R4", "w_restore", 32'(w_restore), 32'(e_w));
    chk(s ? "R3" : "R4", "status_restore", 32'(status_restore), 32'(e_st));
    chk(s ? "R3" : "R4", "bsr_restore", 32'(bsr_restore), 32'(e_b));
    chk("R9", "underflow", 32'(stk_underflow), 32'(m_uf));
    idle();
    chk("R6", "pc_load falls", 32'(pc_load), 32'd0);
    chk("R6", "flush falls", 32'(flush), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    arst_n = 1'b0; phase = 2'd0; instr = '0; instr_valid = 1'b0;
    push_req = 1'b0; push_addr = '0; w_live = '0; status_live = '0; bsr_live = '0;
    m_lvl = 0; m_uf = 1'b0; m_w = '0; m_st = '0; m_b = '0;
    e_w = '0; e_st = '0; e_b = '0; e_pc = '0;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10", "level", 32'(stk_level), 32'd0);
    chk("R10", "underflow", 32'(stk_underflow), 32'd0);
    chk("R10", "pc_next", 32'(pc_next), 32'd0);
    chk("R10", "strobes", {28'd0, pc_load, w_we, status_we, bsr_we}, 32'd0);
    chk("R10", "restore values", {12'd0, w_restore, status_restore, bsr_restore}, 32'd0);
    arst_n = 1'b1;
    idle();
    idle();

    // Table walk: R2, R3, R4, R8
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42:41] == 2'd0)
        do_push(VEC[i][40:20], VEC[i][19:12], VEC[i][11:4], VEC[i][3:0]);
      else
        do_ret(VEC[i][42:41] == 2'd2);
    end

    // R1: non-return words, invalid return, return outside phase 0
    do_push(21'h00ABC, 8'h5A, 8'hA5, 4'h9);
    icycle(16'h0014, 1'b1, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    chk("R1", "0x0014 no pop", {31'd0, pc_load}, 32'd0);
    icycle(16'h0011, 1'b1, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    chk("R1", "0x0011 no pop", {31'd0, pc_load}, 32'd0);
    icycle(16'h0113, 1'b1, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    chk("R1", "0x0113 no pop", {31'd0, pc_load}, 32'd0);
    icycle(16'h0012, 1'b0, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    chk("R1", "invalid return no pop", {31'd0, pc_load}, 32'd0);
    for (int p = 0; p < 4; p++) begin
      phase = 2'(p);
      instr = 16'h0013;
      instr_valid = (p == 2);
      @(negedge clk);
    end
    instr_valid = 1'b0;
    chk("R1", "return in phase 2 no pop", {31'd0, pc_load}, 32'd0);
    chk("R1", "level unchanged", 32'(stk_level), 32'(m_lvl));

    // R5: nothing before the phase-3 edge, pop right after it
    for (int p = 0; p < 3; p++) begin
      phase = 2'(p);
      instr = (p == 0) ? 16'h0012 : 16'h0000;
      instr_valid = (p == 0);
      @(negedge clk);
      chk("R5", "no early pop", {31'd0, pc_load}, 32'd0);
      chk("R5", "level held", 32'(stk_level), 32'(m_lvl));
    end
    instr_valid = 1'b0;
    phase = 2'd3;
    @(negedge clk);
    model_pop(1'b0);
    chk("R5", "pop after phase 3", {31'd0, pc_load}, 32'd1);
    chk("R5", "pc_next", 32'(pc_next), 32'(e_pc));
    idle();

    // R7: return word in the second cycle is ignored
    do_push(21'h00111, 8'h01, 8'h02, 4'h3);
    do_push(21'h00222, 8'h04, 8'h05, 4'h6);
    icycle(16'h0012, 1'b1, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    model_pop(1'b0);
    chk("R7", "first pop pc", 32'(pc_next), 32'(e_pc));
    icycle(16'h0013, 1'b1, 1'b0, 21'h0, 8'h0, 8'h0, 4'h0);
    chk("R7", "second-cycle return ignored", {30'd0, pc_load, w_we}, 32'd0);
    chk("R7", "level unchanged", 32'(stk_level), 32'(m_lvl));
    idle();
    chk("R7", "no late pop", {31'd0, pc_load}, 32'd0);

    // R9: underflow
    while (m_lvl > 0) do_ret(1'b0);
    do_ret(1'b1);
    chk("R9", "underflow set", 32'(stk_underflow), 32'd1);
    do_push(21'h00777, 8'h10, 8'h20, 4'h7);
    do_ret(1'b0);
    chk("R9", "underflow sticky", 32'(stk_underflow), 32'd1);

    // R8: full stack drops the extra push
    for (int k = 0; k < 32; k++)
      do_push(21'(32'h300 + k), 8'(k), 8'(k + 1), 4'(k));
    chk("R8", "level capped", 32'(stk_level), 32'd31);
    do_ret(1'b1);
    chk("R8", "pop after full", 32'(pc_next), 32'h31E);

    // R10: reset in mid-run
    arst_n = 1'b0;
    @(negedge clk);
    chk("R10", "level after reset", 32'(stk_level), 32'd0);
    chk("R10", "underflow cleared", 32'(stk_underflow), 32'd0);
    chk("R10", "pc_next cleared", 32'(pc_next), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule